// File: doc/BRIEF.md
# Address Translation Cache with Access Permission Check

This block caches recent virtual-to-physical page mappings for a requester that needs translations one at a time. A request carries a virtual address, a read/write flag and a supervisor flag. The virtual page number of the request is compared against every cached mapping in parallel. On a match the physical address is returned one cycle after the request is accepted, with no walker traffic. The access can still be refused with a protection fault when the cached permission bits do not allow it.

When no entry matches, the block issues a request to an external page table walker and waits for the walker's answer. A successful answer is installed in the cache and also used to complete the pending translation, with the same permission check. The install goes to a free slot if there is one, and otherwise to the slot named by a rotating pointer. A walker page fault is passed straight back to the requester and nothing is installed. A single-cycle flush input drops every cached mapping.

Top module: `tlb_xlate`

## Requirements
- R1: After reset the cache holds no mappings: `req_ready` is 1, `rsp_valid` and `walk_req_valid` are 0, and the first access to any page goes to the walker.
- R2: A request accepted on a clock edge that hits returns `rsp_valid` in the following cycle, with `rsp_paddr` = {cached frame, low PAGE_W address bits}, and no walker request is raised for it.
- R3: On a miss, `walk_req_valid` is raised with `walk_req_vpn` equal to the request's page number and held stable until `walk_req_ready`. The response to the requester appears in the same cycle that `walk_rsp_valid` is high, with `rsp_paddr` = {`walk_rsp_ppn`, low address bits}.
- R4: After a successful refill, a repeated access to the same page hits and returns the installed frame.
- R5: A read (`req_write`=0) needs the entry's read permission. Without it `rsp_prot_fault` is 1. This holds on hits and on refills.
- R6: A write (`req_write`=1) needs the entry's write permission. Without it `rsp_prot_fault` is 1. This holds on hits and on refills.
- R7: An entry marked supervisor-only gives `rsp_prot_fault`=1 unless `req_super` is 1.
- R8: When the walker answers with `walk_rsp_fault`=1, the requester sees `rsp_page_fault`=1 and `rsp_prot_fault`=0, and no entry is installed, so a repeat access misses again.
- R9: A refill takes the lowest-numbered free slot. When all ENTRIES slots are full, it takes the slot at a rotating pointer that starts at 0 and advances by one after each such eviction.
- R10: A `flush` pulse removes all mappings within one cycle, so any later access misses.
- R11: When `flush` is high in the same cycle as a walker answer, the answer is still delivered to the requester but the mapping is not kept.
- R12: No two slots ever match the same page, and every hit returns the frame installed for that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop all cached mappings |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_super | input | 1 | Requester runs in supervisor mode |
| rsp_valid | output | 1 | One-cycle translation result |
| rsp_paddr | output | PA_W | Physical address |
| rsp_prot_fault | output | 1 | Access refused by permission bits |
| rsp_page_fault | output | 1 | Walker found no mapping |
| walk_req_valid | output | 1 | Walk request |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpn | output | VA_W-PAGE_W | Page number to walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_fault | input | 1 | Walker reports a page fault |
| walk_rsp_ppn | input | PA_W-PAGE_W | Frame number from the walker |
| walk_rsp_sup | input | 1 | Page is supervisor-only |
| walk_rsp_read | input | 1 | Page is readable |
| walk_rsp_write | input | 1 | Page is writable |

## Verification
Two things can fall in the same cycle: a flush and the install of a walker answer. The bench raises `flush` in exactly the cycle in which it drives `walk_rsp_valid`. It then judges the result at the ports. The pending translation must still come back with the walker's frame, and a repeat access to that page must raise a fresh walker request instead of hitting. A flush in an idle cycle that falls between a refill and a re-access is checked separately.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef struct packed {
        logic sup;
        logic rd;
        logic wr;
    } perm_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WREQ,
        ST_WAIT
    } xl_state_e;

endpackage

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
    import tlb_pkg::*;
(
    input  perm_t perm_i,
    input  logic  write_i,
    input  logic  super_i,
    output logic  fault_o
);

    logic kind_bad;
    logic mode_bad;

    always_comb begin
        kind_bad = write_i ? !perm_i.wr : !perm_i.rd;
        mode_bad = perm_i.sup && !super_i;
        fault_o  = kind_bad || mode_bad;
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               alloc_i,
    output logic [IDX_W-1:0]   victim_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [IDX_W-1:0] free_idx;
    logic             full;

    always_comb begin
        full     = &valid_i;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx = IDX_W'(i);
        end
        victim_o = full ? ptr_q : free_idx;
        ptr_d    = ptr_q;
        if (alloc_i && full) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // R9
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid_i) |-> !valid_i[victim_o]);

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic [VPN_W-1:0]   lkp_vpn_i,
    output logic               lkp_hit_o,
    output logic [IDX_W-1:0]   lkp_idx_o,
    output logic [PPN_W-1:0]   lkp_ppn_o,
    output perm_t              lkp_perm_o,
    output logic [ENTRIES-1:0] valid_o,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [PPN_W-1:0]   wr_ppn_i,
    input  perm_t              wr_perm_i
);

    logic [ENTRIES-1:0] valid_q, valid_d;
    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [VPN_W-1:0]   tag_d  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_d  [ENTRIES];
    perm_t              perm_q [ENTRIES];
    perm_t              perm_d [ENTRIES];
    logic [ENTRIES-1:0] match_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_q[g] && (tag_q[g] == lkp_vpn_i);
    end

    always_comb begin
        lkp_idx_o  = '0;
        lkp_ppn_o  = '0;
        lkp_perm_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                lkp_idx_o  = IDX_W'(i);
                lkp_ppn_o  = ppn_q[i];
                lkp_perm_o = perm_q[i];
            end
        end
        lkp_hit_o = |match_vec;
        valid_o   = valid_q;
    end

    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        ppn_d   = ppn_q;
        perm_d  = perm_q;
        if (wr_en_i) begin
            valid_d[wr_idx_i] = 1'b1;
            tag_d[wr_idx_i]   = lkp_vpn_i;
            ppn_d[wr_idx_i]   = wr_ppn_i;
            perm_d[wr_idx_i]  = wr_perm_i;
        end
        if (flush_i) valid_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                ppn_q[i]  <= '0;
                perm_q[i] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            tag_q   <= tag_d;
            ppn_q   <= ppn_d;
            perm_q  <= perm_d;
        end
    end

    // R12
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PAGE_W  = 12,
    parameter int ENTRIES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic                 req_write,
    input  logic                 req_super,
    output logic                 rsp_valid,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic                 rsp_prot_fault,
    output logic                 rsp_page_fault,
    output logic                 walk_req_valid,
    input  logic                 walk_req_ready,
    output logic [VA_W-PAGE_W-1:0] walk_req_vpn,
    input  logic                 walk_rsp_valid,
    input  logic                 walk_rsp_fault,
    input  logic [PA_W-PAGE_W-1:0] walk_rsp_ppn,
    input  logic                 walk_rsp_sup,
    input  logic                 walk_rsp_read,
    input  logic                 walk_rsp_write
);

    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PPN_W = PA_W - PAGE_W;
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        xl_state_e          st;
        logic [VPN_W-1:0]   vpn;
        logic [PAGE_W-1:0]  off;
        logic               wr;
        logic               sup;
    } xl_regs_t;

    xl_regs_t r_q, r_d;

    logic               c_hit;
    logic [IDX_W-1:0]   c_idx;
    logic [PPN_W-1:0]   c_ppn;
    perm_t              c_perm;
    logic [ENTRIES-1:0] c_valid;
    logic               fill_en;
    logic [IDX_W-1:0]   fill_idx;
    logic [IDX_W-1:0]   victim_idx;
    perm_t              walk_perm;
    perm_t              chk_perm;
    logic               chk_fault;

    always_comb begin
        walk_perm.sup = walk_rsp_sup;
        walk_perm.rd  = walk_rsp_read;
        walk_perm.wr  = walk_rsp_write;
        chk_perm      = (r_q.st == ST_WAIT) ? walk_perm : c_perm;
        fill_idx      = c_hit ? c_idx : victim_idx;
    end

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .IDX_W   (IDX_W)
    ) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .lkp_vpn_i  (r_q.vpn),
        .lkp_hit_o  (c_hit),
        .lkp_idx_o  (c_idx),
        .lkp_ppn_o  (c_ppn),
        .lkp_perm_o (c_perm),
        .valid_o    (c_valid),
        .wr_en_i    (fill_en),
        .wr_idx_i   (fill_idx),
        .wr_ppn_i   (walk_rsp_ppn),
        .wr_perm_i  (walk_perm)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (c_valid),
        .alloc_i  (fill_en && !c_hit),
        .victim_o (victim_idx)
    );

    tlb_perm_chk u_perm (
        .perm_i  (chk_perm),
        .write_i (r_q.wr),
        .super_i (r_q.sup),
        .fault_o (chk_fault)
    );

    always_comb begin
        r_d            = r_q;
        req_ready      = (r_q.st == ST_IDLE);
        rsp_valid      = 1'b0;
        rsp_paddr      = '0;
        rsp_prot_fault = 1'b0;
        rsp_page_fault = 1'b0;
        walk_req_valid = 1'b0;
        walk_req_vpn   = r_q.vpn;
        fill_en        = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.vpn = req_vaddr[VA_W-1:PAGE_W];
                    r_d.off = req_vaddr[PAGE_W-1:0];
                    r_d.wr  = req_write;
                    r_d.sup = req_super;
                    r_d.st  = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (c_hit) begin
                    rsp_valid      = 1'b1;
                    rsp_paddr      = {c_ppn, r_q.off};
                    rsp_prot_fault = chk_fault;
                    r_d.st         = ST_IDLE;
                end else begin
                    r_d.st = ST_WREQ;
                end
            end
            ST_WREQ: begin
                walk_req_valid = 1'b1;
                if (walk_req_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (walk_rsp_valid) begin
                    rsp_valid = 1'b1;
                    r_d.st    = ST_IDLE;
                    if (walk_rsp_fault) begin
                        rsp_page_fault = 1'b1;
                    end else begin
                        rsp_paddr      = {walk_rsp_ppn, r_q.off};
                        rsp_prot_fault = chk_fault;
                        fill_en        = !flush;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_req_ready) |=> (walk_req_valid && $stable(walk_req_vpn)));

    // R8
    pf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && walk_rsp_valid && walk_rsp_fault)
            |-> (rsp_valid && rsp_page_fault && !rsp_prot_fault && !fill_en));

    // R11
    flush_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && r_q.st == ST_WAIT && walk_rsp_valid) |=> (c_valid == '0));

endmodule

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_super = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_prot_fault;
    logic        rsp_page_fault;
    logic        walk_req_valid;
    logic        walk_req_ready = 1'b1;
    logic [19:0] walk_req_vpn;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_fault = 1'b0;
    logic [19:0] walk_rsp_ppn = '0;
    logic        walk_rsp_sup = 1'b0;
    logic        walk_rsp_read = 1'b0;
    logic        walk_rsp_write = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tlb_xlate u_tlb_xlate (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .req_write      (req_write),
        .req_super      (req_super),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_prot_fault (rsp_prot_fault),
        .rsp_page_fault (rsp_page_fault),
        .walk_req_valid (walk_req_valid),
        .walk_req_ready (walk_req_ready),
        .walk_req_vpn   (walk_req_vpn),
        .walk_rsp_valid (walk_rsp_valid),
        .walk_rsp_fault (walk_rsp_fault),
        .walk_rsp_ppn   (walk_rsp_ppn),
        .walk_rsp_sup   (walk_rsp_sup),
        .walk_rsp_read  (walk_rsp_read),
        .walk_rsp_write (walk_rsp_write)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] frame_of(input logic [19:0] vpn);
        return vpn ^ 20'h5a5a5;
    endfunction

    // One translation; the walker model answers with ppn/perm/fault when a walk is raised.
    task automatic access(input logic [19:0] vpn, input logic wr, input logic sup,
                          input logic exp_miss, input logic [19:0] ppn,
                          input logic ps, input logic pr, input logic pw,
                          input logic wflt, input logic fl,
                          input logic exp_prot, input logic exp_pf, input string req);
        logic [11:0] off;
        logic        got_miss;
        int          n;
        off = vpn[11:0] ^ 12'h3c7;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        req_write = wr;
        req_super = sup;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        got_miss = !rsp_valid;
        check(got_miss == exp_miss, req, "miss", got_miss, exp_miss);
        if (!got_miss) begin
            check(walk_req_valid == 1'b0, req, "walk on hit", walk_req_valid, 0);
            check(rsp_paddr == {ppn, off}, req, "hit paddr", rsp_paddr, {ppn, off});
            check(rsp_prot_fault == exp_prot, req, "hit prot", rsp_prot_fault, exp_prot);
            check(rsp_page_fault == 1'b0, req, "hit pf", rsp_page_fault, 0);
        end else begin
            n = 0;
            while (!walk_req_valid && n < 10) begin
                @(negedge clk);
                n++;
            end
            check(walk_req_valid == 1'b1, req, "walk raised", walk_req_valid, 1);
            check(walk_req_vpn == vpn, req, "walk vpn", walk_req_vpn, vpn);
            @(negedge clk);
            walk_rsp_valid = 1'b1;
            walk_rsp_fault = wflt;
            walk_rsp_ppn   = ppn;
            walk_rsp_sup   = ps;
            walk_rsp_read  = pr;
            walk_rsp_write = pw;
            flush          = fl;
            #1;
            check(rsp_valid == 1'b1, req, "refill rsp", rsp_valid, 1);
            if (!exp_pf)
                check(rsp_paddr == {ppn, off}, req, "refill paddr", rsp_paddr, {ppn, off});
            check(rsp_prot_fault == exp_prot, req, "refill prot", rsp_prot_fault, exp_prot);
            check(rsp_page_fault == exp_pf, req, "refill pf", rsp_page_fault, exp_pf);
            @(posedge clk);
            #1;
            walk_rsp_valid = 1'b0;
            walk_rsp_fault = 1'b0;
            flush          = 1'b0;
        end
    endtask

    task automatic flush_pulse();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        check(walk_req_valid == 1'b0, "R1", "walk", walk_req_valid, 0);
        access(20'h00001, 1'b0, 1'b0, 1'b1, frame_of(20'h00001), 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R1");
    endtask

    task automatic t_hit();
        // R3 refill, then R2/R4 hits with the installed frame
        access(20'h00005, 1'b0, 1'b0, 1'b1, 20'h00123, 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R3");
        access(20'h00005, 1'b0, 1'b0, 1'b0, 20'h00123, 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R4");
        access(20'h00005, 1'b1, 1'b1, 1'b0, 20'h00123, 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R2");
    endtask

    task automatic t_perm();
        // read-only user page: write faults on refill and on hit, read passes
        access(20'h00010, 1'b1, 1'b0, 1'b1, 20'h00a10, 1'b0, 1'b1, 1'b0,
               1'b0, 1'b0, 1'b1, 1'b0, "R6");
        access(20'h00010, 1'b0, 1'b0, 1'b0, 20'h00a10, 1'b0, 1'b1, 1'b0,
               1'b0, 1'b0, 1'b0, 1'b0, "R5");
        access(20'h00010, 1'b1, 1'b1, 1'b0, 20'h00a10, 1'b0, 1'b1, 1'b0,
               1'b0, 1'b0, 1'b1, 1'b0, "R6");
        // supervisor-only page
        access(20'h00011, 1'b0, 1'b0, 1'b1, 20'h00a11, 1'b1, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b1, 1'b0, "R7");
        access(20'h00011, 1'b0, 1'b1, 1'b0, 20'h00a11, 1'b1, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R7");
        access(20'h00011, 1'b1, 1'b0, 1'b0, 20'h00a11, 1'b1, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b1, 1'b0, "R7");
        // write-only page: read faults on refill and hit, write passes
        access(20'h00012, 1'b0, 1'b0, 1'b1, 20'h00a12, 1'b0, 1'b0, 1'b1,
               1'b0, 1'b0, 1'b1, 1'b0, "R5");
        access(20'h00012, 1'b0, 1'b1, 1'b0, 20'h00a12, 1'b0, 1'b0, 1'b1,
               1'b0, 1'b0, 1'b1, 1'b0, "R5");
        access(20'h00012, 1'b1, 1'b0, 1'b0, 20'h00a12, 1'b0, 1'b0, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R6");
    endtask

    task automatic t_pfault();
        access(20'h00020, 1'b0, 1'b0, 1'b1, 20'h00b20, 1'b0, 1'b1, 1'b1,
               1'b1, 1'b0, 1'b0, 1'b1, "R8");
        access(20'h00020, 1'b0, 1'b0, 1'b1, 20'h00b20, 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_flush();
        flush_pulse();
        access(20'h00005, 1'b0, 1'b0, 1'b1, 20'h00123, 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R10");
        access(20'h00020, 1'b0, 1'b0, 1'b1, 20'h00b20, 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R10");
    endtask

    task automatic t_flush_fill();
        access(20'h00030, 1'b0, 1'b0, 1'b1, 20'h00c30, 1'b0, 1'b1, 1'b1,
               1'b0, 1'b1, 1'b0, 1'b0, "R11");
        access(20'h00030, 1'b0, 1'b0, 1'b1, 20'h00c30, 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R11");
    endtask

    task automatic t_victim();
        logic [19:0] v;
        flush_pulse();
        for (int i = 0; i < 8; i++) begin
            v = 20'h00100 + 20'(i);
            access(v, 1'b0, 1'b0, 1'b1, frame_of(v), 1'b0, 1'b1, 1'b1,
                   1'b0, 1'b0, 1'b0, 1'b0, "R9");
        end
        for (int i = 0; i < 8; i++) begin
            v = 20'h00100 + 20'(i);
            access(v, 1'b0, 1'b0, 1'b0, frame_of(v), 1'b0, 1'b1, 1'b1,
                   1'b0, 1'b0, 1'b0, 1'b0, "R12");
        end
        // full: slot 0 (page 0x100) is evicted first
        access(20'h00108, 1'b0, 1'b0, 1'b1, frame_of(20'h00108), 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R9");
        access(20'h00101, 1'b0, 1'b0, 1'b0, frame_of(20'h00101), 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R9");
        access(20'h00108, 1'b0, 1'b0, 1'b0, frame_of(20'h00108), 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R12");
        // page 0x100 misses and takes slot 1 (page 0x101)
        access(20'h00100, 1'b0, 1'b0, 1'b1, frame_of(20'h00100), 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R9");
        // page 0x101 misses and takes slot 2 (page 0x102)
        access(20'h00101, 1'b0, 1'b0, 1'b1, frame_of(20'h00101), 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R9");
        access(20'h00103, 1'b0, 1'b0, 1'b0, frame_of(20'h00103), 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R9");
        access(20'h00102, 1'b0, 1'b0, 1'b1, frame_of(20'h00102), 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R9");
        access(20'h00100, 1'b0, 1'b0, 1'b0, frame_of(20'h00100), 1'b0, 1'b1, 1'b1,
               1'b0, 1'b0, 1'b0, 1'b0, "R12");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hit();
        t_perm();
        t_pfault();
        t_flush();
        t_flush_fill();
        t_victim();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule